// File: doc/BRIEF.md
# Interrupt and Sleep-Wake Controller

This block holds the interrupt bookkeeping and power-state logic of a small 8-bit microcontroller core. Three internal sources deliver one-cycle event pulses: a timer and two counters. Eight external interrupt pins pass through a synchronizer and a falling-edge detector. Each source owns one bit of a flag register. A flag latches an event only while that source's bit in the mask register is set. Software can overwrite both registers. A global interrupt enable is set and cleared by instruction strobes from the decoder. When an unmasked flag is pending and the global enable is on, the block sends the fetch unit a one-cycle redirect to address 0x008. In the same cycle it drops the global enable, so the handler is not entered again at once.

The block also tracks a sleep state. A sleep-instruction strobe puts the part to sleep unless a control bit blocks it. While asleep, the CPU clock enable and the crystal enable are held low. Three events end sleep: a watchdog timeout, an unmasked external pin edge, or the reset pin driven low. None of them resumes execution. Each raises a one-cycle reset request that the chip's reset logic turns into a full restart at address 0x000.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After synchronous reset, the flag register, mask register, global enable, vector request and reset request are all 0, and the CPU clock enable and crystal enable are both 1.
- R2: Flag bit i goes to 1 on a source event only if mask bit i is 1 in the cycle of the event. Bits 0, 1 and 2 are the timer, counter 1 and counter 2. Bits 3 to 10 are external pins 0 to 7.
- R3: A falling edge on an external pin is a single event. The pin value is sampled at clock edge k, and the flag is visible after edge k+2. A rising edge produces no event.
- R4: A flag write replaces the flag register with the written value. If a write and an unmasked event for the same bit fall in the same cycle, the bit ends at 1.
- R5: The enable-strobe sets the global enable and the disable-strobe clears it. When both arrive together, the enable ends at 0. With neither strobe, the enable holds its value.
- R6: If the global enable is 1, the part is awake and (flag AND mask) is nonzero before an edge, then after that edge the vector request is 1 for exactly one cycle, the vector address reads 0x008, and the global enable reads 0. Pending flags whose mask bit is 0 never vector.
- R7: Taking a vector leaves every flag bit unchanged.
- R8: A sleep strobe with the block bit at 0 enters sleep at the next edge, and the clock and crystal enables go to 0. With the block bit at 1, the strobe is ignored.
- R9: While asleep, a watchdog timeout, a low reset pin, or an unmasked external edge causes a one-cycle reset request and leaves sleep in the same edge. Masked external edges, internal events and flag activity do not wake the part, and no vector is issued while asleep. A watchdog timeout while awake raises no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_evt_i | input | 3 | Event pulses: bit 0 timer, bit 1 counter 1, bit 2 counter 2 |
| ext_pin_i | input | 8 | External interrupt pins, idle high |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 11 | Flag register write data |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 11 | Mask register write data |
| eni_stb_i | input | 1 | Global enable set strobe |
| disi_stb_i | input | 1 | Global enable clear strobe |
| slep_stb_i | input | 1 | Sleep instruction strobe |
| slp_block_i | input | 1 | Control bit; 1 blocks sleep entry |
| wdt_tmo_i | input | 1 | Watchdog timeout pulse |
| rst_pin_n_i | input | 1 | Reset pin, active low |
| flag_o | output | 11 | Flag register |
| mask_o | output | 11 | Mask register |
| gie_o | output | 1 | Global interrupt enable |
| vec_req_o | output | 1 | One-cycle fetch redirect request |
| vec_addr_o | output | 12 | Redirect address, 0x008 while vec_req_o is 1 |
| sleeping_o | output | 1 | Sleep state |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| xtal_en_o | output | 1 | Crystal enable |
| wake_rst_o | output | 1 | One-cycle reset request on wake |

## Verification
The bench builds the block with its default sizes: three internal sources and eight external pins. That small configuration puts all eleven flag positions in reach of an exhaustive sweep. Each source is driven with its mask bit both clear and set, and every mask pattern over the three internal sources is applied to simultaneous events. Every combination of the two enable strobes is tried from both starting enable values. The sleep sweep covers every wake cause, plus the masked, internal and blocked cases that must leave the part asleep.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  localparam int FETCH_W = 12;
  localparam logic [FETCH_W-1:0] VEC_IRQ = 12'h008;
  localparam logic [FETCH_W-1:0] VEC_RST = 12'h000;
  typedef enum logic {PS_RUN = 1'b0, PS_SLEEP = 1'b1} pwr_state_e;
endpackage

// File: rtl/ext_fall_detect.sv
module ext_fall_detect #(
  parameter int N_PIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_PIN-1:0] pin_i,
  output logic [N_PIN-1:0] fall_o
);
  // two synchronizer stages plus one history stage per pin; idle level is high
  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= pin_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign fall_o[g] = s3_q & ~s2_q;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      fall_o[g] |=> !fall_o[g]); // R3
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_SRC = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             flag_wr_i,
  input  logic [N_SRC-1:0] flag_wdata_i,
  input  logic             mask_wr_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] mask_o
);
  logic [N_SRC-1:0] flag_q, mask_q, flag_base, flag_nxt, hit;

  always_comb begin
    hit       = evt_i & mask_q;
    flag_base = flag_wr_i ? flag_wdata_i : flag_q;
    flag_nxt  = flag_base | hit;   // a new event beats a software clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_nxt;
      if (mask_wr_i) mask_q <= mask_wdata_i;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;

  AST_FLAG_ONLY_MASKED: assert property (@(posedge clk) disable iff (rst)
    !flag_wr_i |=> ((flag_o & ~$past(flag_o) & ~$past(mask_o)) == '0)); // R2
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (flag_wr_i && ((evt_i & mask_o) != '0))
      |=> ((flag_o & $past(evt_i & mask_o)) == $past(evt_i & mask_o))); // R4
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_wake_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pending_i,
  input  logic               eni_i,
  input  logic               disi_i,
  input  logic               hold_i,
  output logic               gie_o,
  output logic               vec_req_o,
  output logic [FETCH_W-1:0] vec_addr_o
);
  logic gie_q, req_q, take;
  logic [FETCH_W-1:0] addr_q;

  assign take = gie_q & pending_i & ~hold_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      req_q  <= 1'b0;
      addr_q <= VEC_RST;
    end else begin
      if (take)        gie_q <= 1'b0;
      else if (disi_i) gie_q <= 1'b0;
      else if (eni_i)  gie_q <= 1'b1;
      req_q  <= take;
      addr_q <= take ? VEC_IRQ : VEC_RST;
    end
  end

  assign gie_o      = gie_q;
  assign vec_req_o  = req_q;
  assign vec_addr_o = addr_q;

  AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |=> !vec_req_o); // R6
  AST_VEC_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> !gie_o); // R6
  AST_VEC_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> $past(gie_o)); // R5
  AST_NO_VEC_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> !$past(hold_i)); // R9
endmodule

// File: rtl/pwr_sleep_fsm.sv
module pwr_sleep_fsm
  import irq_wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic slep_i,
  input  logic slp_block_i,
  input  logic wdt_i,
  input  logic rst_pin_n_i,
  input  logic ext_wake_i,
  output logic sleeping_o,
  output logic clk_en_o,
  output logic xtal_en_o,
  output logic wake_rst_o
);
  pwr_state_e st_q, st_nxt;
  logic clk_en_q, xtal_en_q, wake_q, wake_hit;

  assign wake_hit = wdt_i | ~rst_pin_n_i | ext_wake_i;

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      PS_RUN:   if (slep_i && !slp_block_i) st_nxt = PS_SLEEP;
      PS_SLEEP: if (wake_hit) st_nxt = PS_RUN;
      default:  st_nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PS_RUN;
      clk_en_q  <= 1'b1;
      xtal_en_q <= 1'b1;
      wake_q    <= 1'b0;
    end else begin
      st_q      <= st_nxt;
      clk_en_q  <= (st_nxt == PS_RUN);
      xtal_en_q <= (st_nxt == PS_RUN);
      wake_q    <= (st_q == PS_SLEEP) && wake_hit;
    end
  end

  assign sleeping_o = (st_q == PS_SLEEP);
  assign clk_en_o   = clk_en_q;
  assign xtal_en_o  = xtal_en_q;
  assign wake_rst_o = wake_q;

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(sleeping_o) |-> $past(slep_i && !slp_block_i)); // R8
  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (rst)
    wake_rst_o |-> ($past(sleeping_o) && !sleeping_o)); // R9
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wake_rst_o |=> !wake_rst_o); // R9
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int N_INT = 3,
  parameter int N_EXT = 8,
  localparam int N_SRC = N_INT + N_EXT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_INT-1:0]   int_evt_i,
  input  logic [N_EXT-1:0]   ext_pin_i,
  input  logic               flag_wr_i,
  input  logic [N_SRC-1:0]   flag_wdata_i,
  input  logic               mask_wr_i,
  input  logic [N_SRC-1:0]   mask_wdata_i,
  input  logic               eni_stb_i,
  input  logic               disi_stb_i,
  input  logic               slep_stb_i,
  input  logic               slp_block_i,
  input  logic               wdt_tmo_i,
  input  logic               rst_pin_n_i,
  output logic [N_SRC-1:0]   flag_o,
  output logic [N_SRC-1:0]   mask_o,
  output logic               gie_o,
  output logic               vec_req_o,
  output logic [FETCH_W-1:0] vec_addr_o,
  output logic               sleeping_o,
  output logic               cpu_clk_en_o,
  output logic               xtal_en_o,
  output logic               wake_rst_o
);
  logic [N_EXT-1:0] ext_fall;
  logic [N_SRC-1:0] src_evt;
  logic             pending, ext_wake;

  ext_fall_detect #(.N_PIN(N_EXT)) u_edge (
    .clk(clk), .rst(rst), .pin_i(ext_pin_i), .fall_o(ext_fall)
  );

  assign src_evt = {ext_fall, int_evt_i};

  irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk(clk), .rst(rst), .evt_i(src_evt),
    .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
    .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
    .flag_o(flag_o), .mask_o(mask_o)
  );

  assign pending  = |(flag_o & mask_o);
  assign ext_wake = |(ext_fall & mask_o[N_SRC-1:N_INT]);

  irq_vector_unit u_vec (
    .clk(clk), .rst(rst), .pending_i(pending),
    .eni_i(eni_stb_i), .disi_i(disi_stb_i), .hold_i(sleeping_o),
    .gie_o(gie_o), .vec_req_o(vec_req_o), .vec_addr_o(vec_addr_o)
  );

  pwr_sleep_fsm u_pwr (
    .clk(clk), .rst(rst), .slep_i(slep_stb_i), .slp_block_i(slp_block_i),
    .wdt_i(wdt_tmo_i), .rst_pin_n_i(rst_pin_n_i), .ext_wake_i(ext_wake),
    .sleeping_o(sleeping_o), .clk_en_o(cpu_clk_en_o), .xtal_en_o(xtal_en_o),
    .wake_rst_o(wake_rst_o)
  );

  AST_VEC_ADDR: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> (vec_addr_o == VEC_IRQ)); // R6
  AST_VEC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (vec_req_o && !$past(flag_wr_i)) |-> ((flag_o & $past(flag_o)) == $past(flag_o))); // R7
endmodule

// File: tb/irq_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_wake_ctrl_tb_top;
  localparam int NI = 3;
  localparam int NE = 8;
  localparam int NS = NI + NE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0] int_evt = '0;
  logic [NE-1:0] ext_pin = '1;
  logic flag_wr = 1'b0, mask_wr = 1'b0;
  logic [NS-1:0] flag_wdata = '0, mask_wdata = '0;
  logic eni = 1'b0, disi = 1'b0, slep = 1'b0, blk = 1'b0, wdt = 1'b0, rpin_n = 1'b1;
  logic [NS-1:0] flag_q, mask_q;
  logic gie, vec_req, sleeping, clk_en, xtal_en, wake_rst;
  logic [11:0] vec_addr;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  irq_wake_ctrl #(.N_INT(NI), .N_EXT(NE)) dut_i (
    .clk(clk), .rst(rst), .int_evt_i(int_evt), .ext_pin_i(ext_pin),
    .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
    .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata),
    .eni_stb_i(eni), .disi_stb_i(disi), .slep_stb_i(slep), .slp_block_i(blk),
    .wdt_tmo_i(wdt), .rst_pin_n_i(rpin_n),
    .flag_o(flag_q), .mask_o(mask_q), .gie_o(gie), .vec_req_o(vec_req),
    .vec_addr_o(vec_addr), .sleeping_o(sleeping), .cpu_clk_en_o(clk_en),
    .xtal_en_o(xtal_en), .wake_rst_o(wake_rst)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<=50000 cycles", cyc);
      report();
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; int_evt = '0; ext_pin = '1; flag_wr = 0; mask_wr = 0;
    eni = 0; disi = 0; slep = 0; blk = 0; wdt = 0; rpin_n = 1;
    repeat (2) tick();
    rst = 1'b0;
  endtask

  task automatic set_mask(input logic [NS-1:0] v);
    mask_wr = 1'b1; mask_wdata = v; tick(); mask_wr = 1'b0;
  endtask

  task automatic ext_low(input int p);
    ext_pin[p] = 1'b0; repeat (3) tick();
  endtask

  task automatic ext_high(input int p);
    ext_pin[p] = 1'b1; repeat (3) tick();
  endtask

  initial begin
    tick();
    do_reset();
    // R1 reset state
    chk("R1 flags", 32'(flag_q), 0);
    chk("R1 mask", 32'(mask_q), 0);
    chk("R1 gie", 32'(gie), 0);
    chk("R1 vec", 32'(vec_req), 0);
    chk("R1 wake", 32'(wake_rst), 0);
    chk("R1 clk_en", 32'(clk_en), 1);
    chk("R1 xtal_en", 32'(xtal_en), 1);

    // R2 / R3 sweep of every source with its mask bit clear and set
    for (int s = 0; s < NS; s++) begin
      for (int m = 0; m < 2; m++) begin
        do_reset();
        set_mask(m ? (NS'(1) << s) : '0);
        if (s < NI) begin
          int_evt[s] = 1'b1; tick(); int_evt = '0;
          chk("R2 internal source", 32'(flag_q), m ? (32'd1 << s) : 0);
        end else begin
          ext_low(s - NI);
          chk("R3 falling edge", 32'(flag_q), m ? (32'd1 << s) : 0);
          flag_wr = 1'b1; flag_wdata = '0; tick(); flag_wr = 1'b0;
          ext_high(s - NI);
          chk("R3 rising edge ignored", 32'(flag_q), 0);
        end
      end
    end

    // R2 all internal mask patterns against simultaneous events
    for (int m = 0; m < 8; m++) begin
      do_reset();
      set_mask(NS'(m));
      int_evt = '1; tick(); int_evt = '0;
      chk("R2 mask pattern", 32'(flag_q), 32'(m));
    end

    // R3 all pins falling together, mask all set
    do_reset();
    set_mask('1);
    ext_pin = '0; repeat (2) tick();
    chk("R3 latency two edges", 32'(flag_q), 0);
    tick();
    chk("R3 all pins", 32'(flag_q), 32'h7F8);
    ext_pin = '1; repeat (3) tick();

    // R4 software write versus event
    do_reset();
    set_mask(NS'(1));
    int_evt = 3'b001; tick(); int_evt = '0;
    flag_wr = 1; flag_wdata = '0; int_evt = 3'b001; tick(); int_evt = '0; flag_wr = 0;
    chk("R4 event beats clear", 32'(flag_q), 1);
    flag_wr = 1; flag_wdata = '0; tick(); flag_wr = 0;
    chk("R4 clear", 32'(flag_q), 0);
    flag_wr = 1; flag_wdata = NS'(11'h400); int_evt = 3'b001; tick(); int_evt = '0; flag_wr = 0;
    chk("R4 write plus event", 32'(flag_q), 32'h401);

    // R5 every strobe combination from both starting values
    for (int st = 0; st < 2; st++) begin
      for (int c = 0; c < 4; c++) begin
        do_reset();
        if (st == 1) begin eni = 1; tick(); eni = 0; end
        eni = c[0]; disi = c[1]; tick(); eni = 0; disi = 0;
        chk("R5 gie strobes", 32'(gie), c[1] ? 0 : (c[0] ? 1 : st));
      end
    end

    // R6 / R7 vectoring
    do_reset();
    set_mask(NS'(1));
    eni = 1; tick(); eni = 0;
    int_evt = 3'b001; tick(); int_evt = '0;
    chk("R6 no vec before flag seen", 32'(vec_req), 0);
    tick();
    chk("R6 vec request", 32'(vec_req), 1);
    chk("R6 vec address", 32'(vec_addr), 32'h008);
    chk("R6 gie cleared", 32'(gie), 0);
    chk("R7 flag kept", 32'(flag_q), 1);
    tick();
    chk("R6 vec single cycle", 32'(vec_req), 0);
    chk("R7 flag still kept", 32'(flag_q), 1);
    eni = 1; tick(); eni = 0; tick();
    chk("R6 re-vector on pending flag", 32'(vec_req), 1);
    tick();
    set_mask('0);
    eni = 1; tick(); eni = 0; repeat (2) tick();
    chk("R6 masked pending ignored", 32'(vec_req), 0);
    chk("R6 gie held", 32'(gie), 1);

    // R8 sleep entry
    do_reset();
    slep = 1; blk = 1; tick(); slep = 0; blk = 0;
    chk("R8 blocked sleep", 32'(sleeping), 0);
    chk("R8 blocked clk_en", 32'(clk_en), 1);
    wdt = 1; tick(); wdt = 0;
    chk("R9 wdt awake no reset", 32'(wake_rst), 0);
    slep = 1; tick(); slep = 0;
    chk("R8 sleeping", 32'(sleeping), 1);
    chk("R8 clk_en off", 32'(clk_en), 0);
    chk("R8 xtal off", 32'(xtal_en), 0);

    // R9 non-waking activity while asleep
    set_mask(NS'(3'b111));
    eni = 1; tick(); eni = 0;
    int_evt = '1; tick(); int_evt = '0; repeat (2) tick();
    chk("R9 internal no wake", 32'(sleeping), 1);
    chk("R9 no vec asleep", 32'(vec_req), 0);
    chk("R9 no reset req", 32'(wake_rst), 0);
    ext_low(0);
    chk("R9 masked ext no wake", 32'(sleeping), 1);
    ext_high(0);
    flag_wr = 1; flag_wdata = '0; mask_wr = 1; mask_wdata = NS'(11'h008); tick();
    flag_wr = 0; mask_wr = 0; disi = 1; tick(); disi = 0;
    ext_low(0);
    chk("R9 ext wake reset req", 32'(wake_rst), 1);
    chk("R9 ext wake awake", 32'(sleeping), 0);
    chk("R9 clk_en back", 32'(clk_en), 1);
    tick();
    chk("R9 reset req single", 32'(wake_rst), 0);
    ext_high(0);

    slep = 1; tick(); slep = 0;
    wdt = 1; tick(); wdt = 0;
    chk("R9 wdt wake", 32'(wake_rst), 1);
    chk("R9 wdt awake", 32'(sleeping), 0);

    slep = 1; tick(); slep = 0;
    rpin_n = 0; tick(); rpin_n = 1;
    chk("R9 pin wake", 32'(wake_rst), 1);
    chk("R9 pin xtal on", 32'(xtal_en), 1);
    tick();
    chk("R9 pin reset single", 32'(wake_rst), 0);

    report();
    $finish;
  end
endmodule